// File: doc/BRIEF.md
# Control Endpoint Transfer Stage Tracker

This block follows a USB control transfer on endpoint zero through its stages. It works from single-cycle event pulses that the surrounding device controller raises:

- a setup packet has arrived, together with its direction bit and a flag for a nonzero data length;
- an IN packet has finished;
- the final IN packet has been sent;
- an OUT packet has arrived, with a flag that marks it as the last one;
- the transfer has completed;
- a stall has been requested.

From these events the block keeps a registered stage code. It decodes that code into three flags: one saying the data stage expects IN traffic, one saying it expects OUT traffic, and one saying the endpoint is halted.

After the final IN packet the block does not return straight to idle. It waits in a separate stage until the completion event confirms that the host has taken the data. A halted endpoint ignores everything except a new setup packet, and that packet clears the halt. Firmware or the packet engine reads the stage code to decide what to do with the next endpoint-zero interrupt.

Parameter `SETUP_PREEMPT` chooses what happens when a setup packet arrives in the middle of a data stage. With 1 (the default) the new setup restarts the transfer. With 0 such a setup is ignored, and setup packets are taken only in the idle and halted stages.

Top module: `ctl_ep_fsm`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, state_o is 1 (idle/setup stage) and expect_in_o, expect_out_o and stall_o are 0. Reset acts asynchronously.
- R2: An accepted setup pulse with setup_dir_in_i=1 and setup_has_data_i=1 makes state_o equal 2 (IN data stage) one clock later.
- R3: An accepted setup pulse with setup_dir_in_i=0 and setup_has_data_i=1 makes state_o equal 3 (OUT data stage) one clock later.
- R4: An accepted setup pulse with setup_has_data_i=0 makes state_o equal 1 one clock later, whatever the direction bit.
- R5: In stage 2, in_last_i moves state_o to 4 (waiting for completion). in_done_i without in_last_i leaves the stage at 2.
- R6: In stage 4, xfer_cmpl_i moves state_o to 1. Without it the stage stays at 4.
- R7: In stage 3, out_rx_i with out_last_i moves state_o to 1. out_rx_i without out_last_i leaves the stage at 3.
- R8: stall_req_i moves state_o to 5 one clock later from any stage, and sets stall_o. It overrides every other event in the same cycle, including a setup.
- R9: In stage 5 only a setup pulse leaves the stage. All other events keep state_o at 5.
- R10: With SETUP_PREEMPT=1 a setup pulse is accepted in every stage. With SETUP_PREEMPT=0 a setup pulse in stages 2, 3 or 4 is ignored and the stage is unchanged.
- R11: Events that do not belong to the current stage leave it unchanged. These are IN events outside stage 2, OUT events outside stage 3, and xfer_cmpl_i outside stage 4.
- R12: state_o only ever takes the values 1 to 5. The output flags decode the stage as follows: expect_in_o is high exactly in stage 2, expect_out_o exactly in stage 3, and stall_o exactly in stage 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| setup_i | input | 1 | Setup packet received (pulse) |
| setup_dir_in_i | input | 1 | Direction bit of the setup: 1 = device to host |
| setup_has_data_i | input | 1 | Setup announces a nonzero data length |
| in_done_i | input | 1 | An IN packet has finished (not the last one) |
| in_last_i | input | 1 | The final IN packet has been sent |
| out_rx_i | input | 1 | An OUT packet has been received |
| out_last_i | input | 1 | The received OUT packet is the last one |
| xfer_cmpl_i | input | 1 | Transfer completion event |
| stall_req_i | input | 1 | Request to halt the endpoint |
| state_o | output | 3 | Stage code: 1 setup, 2 IN data, 3 OUT data, 4 IN wait for completion, 5 stalled |
| expect_in_o | output | 1 | The data stage expects IN traffic |
| expect_out_o | output | 1 | The data stage expects OUT traffic |
| stall_o | output | 1 | The endpoint is halted |

## Verification
The bench builds two copies of the block from the same stimulus. The first uses SETUP_PREEMPT=1, so a setup arriving in the middle of a stage restarts the transfer. The second uses SETUP_PREEMPT=0, so a setup in stages 2, 3 and 4 must leave them unchanged. Running both sides together brings both branches of R10 within reach in every cycle. The same run also covers a stall colliding with a setup, and stray events arriving in every stage.

// File: rtl/ctl_ep_pkg.sv
package ctl_ep_pkg;
  localparam int unsigned ST_W = 3;

  typedef enum logic [ST_W-1:0] {
    ST_SETUP  = 3'd1,
    ST_TX     = 3'd2,
    ST_RX     = 3'd3,
    ST_TX_END = 3'd4,
    ST_STALL  = 3'd5
  } ep0_st_e;

  typedef struct packed {
    logic stall;
    logic setup;
    logic setup_in;
    logic setup_data;
    logic in_done;
    logic in_last;
    logic out_last;
    logic cmpl;
  } ep0_evt_t;
endpackage

// File: rtl/ctl_ep_evt.sv
module ctl_ep_evt
  import ctl_ep_pkg::*;
#(
  parameter bit SETUP_PREEMPT = 1'b1
) (
  input  ep0_st_e  st_i,
  input  logic     setup_i,
  input  logic     setup_dir_in_i,
  input  logic     setup_has_data_i,
  input  logic     in_done_i,
  input  logic     in_last_i,
  input  logic     out_rx_i,
  input  logic     out_last_i,
  input  logic     xfer_cmpl_i,
  input  logic     stall_req_i,
  output ep0_evt_t evt_o
);
  logic setup_ok;

  generate
    if (SETUP_PREEMPT) begin : g_any
      assign setup_ok = 1'b1;
    end else begin : g_idle
      assign setup_ok = (st_i == ST_SETUP) || (st_i == ST_STALL);
    end
  endgenerate

  always_comb begin
    evt_o            = '0;
    evt_o.stall      = stall_req_i;
    // stall outranks a coincident setup
    evt_o.setup      = setup_i & setup_ok & ~stall_req_i;
    evt_o.setup_in   = setup_dir_in_i;
    evt_o.setup_data = setup_has_data_i;
    evt_o.in_done    = in_done_i;
    evt_o.in_last    = in_last_i;
    evt_o.out_last   = out_rx_i & out_last_i;
    evt_o.cmpl       = xfer_cmpl_i;
  end
endmodule

// File: rtl/ctl_ep_next.sv
module ctl_ep_next
  import ctl_ep_pkg::*;
(
  input  ep0_st_e  st_i,
  input  ep0_evt_t evt_i,
  output ep0_st_e  nxt_o
);
  always_comb begin
    nxt_o = st_i;
    if (evt_i.stall) begin
      nxt_o = ST_STALL;
    end else if (evt_i.setup) begin
      if (!evt_i.setup_data)    nxt_o = ST_SETUP;
      else if (evt_i.setup_in)  nxt_o = ST_TX;
      else                      nxt_o = ST_RX;
    end else begin
      unique case (st_i)
        ST_TX: begin
          if (evt_i.in_last)      nxt_o = ST_TX_END;
          else if (evt_i.in_done) nxt_o = ST_TX;
        end
        ST_TX_END: if (evt_i.cmpl)     nxt_o = ST_SETUP;
        ST_RX:     if (evt_i.out_last) nxt_o = ST_SETUP;
        ST_SETUP, ST_STALL: nxt_o = st_i;
        default:   nxt_o = ST_SETUP;
      endcase
    end
  end
endmodule

// File: rtl/ctl_ep_dec.sv
module ctl_ep_dec
  import ctl_ep_pkg::*;
(
  input  ep0_st_e         st_i,
  output logic [ST_W-1:0] state_o,
  output logic            expect_in_o,
  output logic            expect_out_o,
  output logic            stall_o
);
  always_comb begin
    state_o      = st_i;
    expect_in_o  = (st_i == ST_TX);
    expect_out_o = (st_i == ST_RX);
    stall_o      = (st_i == ST_STALL);
  end
endmodule

// File: rtl/ctl_ep_fsm.sv
module ctl_ep_fsm
  import ctl_ep_pkg::*;
#(
  parameter bit SETUP_PREEMPT = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            setup_i,
  input  logic            setup_dir_in_i,
  input  logic            setup_has_data_i,
  input  logic            in_done_i,
  input  logic            in_last_i,
  input  logic            out_rx_i,
  input  logic            out_last_i,
  input  logic            xfer_cmpl_i,
  input  logic            stall_req_i,
  output logic [ST_W-1:0] state_o,
  output logic            expect_in_o,
  output logic            expect_out_o,
  output logic            stall_o
);
  ep0_st_e  st_q, st_d;
  ep0_evt_t evt;

  ctl_ep_evt #(.SETUP_PREEMPT(SETUP_PREEMPT)) u_evt (
    .st_i             (st_q),
    .setup_i          (setup_i),
    .setup_dir_in_i   (setup_dir_in_i),
    .setup_has_data_i (setup_has_data_i),
    .in_done_i        (in_done_i),
    .in_last_i        (in_last_i),
    .out_rx_i         (out_rx_i),
    .out_last_i       (out_last_i),
    .xfer_cmpl_i      (xfer_cmpl_i),
    .stall_req_i      (stall_req_i),
    .evt_o            (evt)
  );

  ctl_ep_next u_next (
    .st_i  (st_q),
    .evt_i (evt),
    .nxt_o (st_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_SETUP;
    else         st_q <= st_d;
  end

  ctl_ep_dec u_dec (
    .st_i         (st_q),
    .state_o      (state_o),
    .expect_in_o  (expect_in_o),
    .expect_out_o (expect_out_o),
    .stall_o      (stall_o)
  );
endmodule

// File: rtl/ctl_ep_fsm_chk.sv
module ctl_ep_fsm_chk #(
  parameter bit SETUP_PREEMPT = 1'b1
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       setup_i,
  input logic       setup_dir_in_i,
  input logic       setup_has_data_i,
  input logic       in_last_i,
  input logic       out_rx_i,
  input logic       out_last_i,
  input logic       xfer_cmpl_i,
  input logic       stall_req_i,
  input logic [2:0] state_o,
  input logic       expect_in_o,
  input logic       expect_out_o,
  input logic       stall_o
);
  logic take;
  assign take = setup_i && !stall_req_i &&
                (SETUP_PREEMPT || state_o == 3'd1 || state_o == 3'd5);

  AST_STALL_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_req_i |=> (state_o == 3'd5 && stall_o)); // R8
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd5 && !setup_i) |=> state_o == 3'd5); // R9
  AST_SETUP_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && setup_dir_in_i && setup_has_data_i) |=> (state_o == 3'd2 && expect_in_o)); // R2
  AST_SETUP_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !setup_dir_in_i && setup_has_data_i) |=> (state_o == 3'd3 && expect_out_o)); // R3
  AST_SETUP_NODATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !setup_has_data_i) |=> state_o == 3'd1); // R4
  AST_TX_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd2 && in_last_i && !take && !stall_req_i) |=> state_o == 3'd4); // R5
  AST_TXEND_CMPL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd4 && xfer_cmpl_i && !take && !stall_req_i) |=> state_o == 3'd1); // R6
  AST_RX_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd3 && out_rx_i && out_last_i && !take && !stall_req_i) |=> state_o == 3'd1); // R7
  AST_NO_PREEMPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!SETUP_PREEMPT && setup_i && !stall_req_i && state_o == 3'd3 && !out_rx_i) |=> state_o == 3'd3); // R10
  AST_IDLE_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd1 && !setup_i && !stall_req_i) |=> state_o == 3'd1); // R11
  AST_CODE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o >= 3'd1 && state_o <= 3'd5)); // R12
  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({expect_in_o, expect_out_o, stall_o})); // R12
endmodule

bind ctl_ep_fsm ctl_ep_fsm_chk #(.SETUP_PREEMPT(SETUP_PREEMPT)) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .setup_i          (setup_i),
  .setup_dir_in_i   (setup_dir_in_i),
  .setup_has_data_i (setup_has_data_i),
  .in_last_i        (in_last_i),
  .out_rx_i         (out_rx_i),
  .out_last_i       (out_last_i),
  .xfer_cmpl_i      (xfer_cmpl_i),
  .stall_req_i      (stall_req_i),
  .state_o          (state_o),
  .expect_in_o      (expect_in_o),
  .expect_out_o     (expect_out_o),
  .stall_o          (stall_o)
);

// File: tb/tb_ctl_ep_fsm.sv
`timescale 1ns/1ps
module tb_ctl_ep_fsm;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic su = 0, dir = 0, len = 0, ind = 0, inl = 0, orx = 0, ol = 0, cm = 0, stq = 0;
  logic [2:0] st_a, st_b;
  logic ei_a, eo_a, sl_a, ei_b, eo_b, sl_b;
  int n_chk = 0, n_fail = 0;
  int mdl [2];

  always #2 clk = ~clk;

  ctl_ep_fsm #(.SETUP_PREEMPT(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .setup_i(su), .setup_dir_in_i(dir),
    .setup_has_data_i(len), .in_done_i(ind), .in_last_i(inl), .out_rx_i(orx),
    .out_last_i(ol), .xfer_cmpl_i(cm), .stall_req_i(stq), .state_o(st_a),
    .expect_in_o(ei_a), .expect_out_o(eo_a), .stall_o(sl_a));

  ctl_ep_fsm #(.SETUP_PREEMPT(1'b0)) dut_hold (
    .clk_i(clk), .rst_ni(rst_n), .setup_i(su), .setup_dir_in_i(dir),
    .setup_has_data_i(len), .in_done_i(ind), .in_last_i(inl), .out_rx_i(orx),
    .out_last_i(ol), .xfer_cmpl_i(cm), .stall_req_i(stq), .state_o(st_b),
    .expect_in_o(ei_b), .expect_out_o(eo_b), .stall_o(sl_b));

  // behavioural reference: stage after one edge, plus which rule applied
  function automatic int ref_next(int s, bit pre, output string tag);
    bit take;
    take = su && (pre || s == 1 || s == 5);
    if (stq) begin tag = "R8"; return 5; end
    if (take) begin
      if (s != 1 && s != 5) tag = "R10";
      else if (!len) tag = "R4";
      else tag = dir ? "R2" : "R3";
      if (!len) return 1;
      return dir ? 2 : 3;
    end
    if (su) tag = "R10";
    else if (s == 5) tag = "R9";
    else tag = "R11";
    if (s == 2) begin
      if (!su) tag = "R5";
      if (inl) return 4;
      return 2;
    end
    if (s == 4) begin
      if (!su) tag = "R6";
      if (cm) return 1;
      return 4;
    end
    if (s == 3) begin
      if (!su) tag = "R7";
      if (orx && ol) return 1;
      return 3;
    end
    return s;
  endfunction

  task automatic check_one(string tag, string who, logic [2:0] st, logic ei, logic eo, logic sl, int exp);
    n_chk++;
    if (st !== exp[2:0] || ei !== (exp == 2) || eo !== (exp == 3) || sl !== (exp == 5)) begin
      n_fail++;
      $display("FAIL %s %s: state/in/out/stall actual %0d/%0b/%0b/%0b expected %0d/%0b/%0b/%0b (R12)",
               tag, who, st, ei, eo, sl, exp, exp == 2, exp == 3, exp == 5);
    end
  endtask

  // called at a negedge: drive, take one edge, compare both copies
  task automatic cyc(bit a_su, bit a_dir, bit a_len, bit a_ind, bit a_inl,
                     bit a_orx, bit a_ol, bit a_cm, bit a_st);
    string t0, t1;
    int e0, e1;
    su = a_su; dir = a_dir; len = a_len; ind = a_ind; inl = a_inl;
    orx = a_orx; ol = a_ol; cm = a_cm; stq = a_st;
    e0 = ref_next(mdl[0], 1'b1, t0);
    e1 = ref_next(mdl[1], 1'b0, t1);
    @(posedge clk);
    mdl[0] = e0; mdl[1] = e1;
    @(negedge clk);
    {su, dir, len, ind, inl, orx, ol, cm, stq} = '0;
    check_one(t0, "preempt", st_a, ei_a, eo_a, sl_a, mdl[0]);
    check_one(t1, "hold", st_b, ei_b, eo_b, sl_b, mdl[1]);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0,0,0,0,0,0,0,0,0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    mdl[0] = 1; mdl[1] = 1;
    repeat (3) @(negedge clk);
    check_one("R1", "preempt", st_a, ei_a, eo_a, sl_a, 1);
    check_one("R1", "hold", st_b, ei_b, eo_b, sl_b, 1);
    rst_n = 1'b1;
    idle(2); // R1 first cycles after release

    // R2 / R5 / R6: IN transfer with an intermediate packet, last, wait, completion
    cyc(1,1,1,0,0,0,0,0,0);
    cyc(0,0,0,1,0,0,0,0,0);
    cyc(0,0,0,0,0,1,1,1,0);      // R11 stray OUT/cmpl in TX
    cyc(0,0,0,0,1,0,0,0,0);
    cyc(0,0,0,1,1,1,1,0,0);      // R11 stray in TX_END
    cyc(0,0,0,0,0,0,0,1,0);
    // R3 / R7: OUT transfer
    cyc(1,0,1,0,0,0,0,0,0);
    cyc(0,0,0,0,0,1,0,0,0);
    cyc(0,0,0,1,1,0,0,1,0);      // R11 IN events in RX
    cyc(0,0,0,0,0,0,1,0,0);      // last without rx strobe
    cyc(0,0,0,0,0,1,1,0,0);
    // R4: zero-length setups of both directions
    cyc(1,1,0,0,0,0,0,0,0);
    cyc(1,0,0,0,0,0,0,0,0);
    // R8 / R9: stall, stray events, exit by setup
    cyc(0,0,0,0,0,0,0,0,1);
    cyc(0,0,0,1,1,1,1,1,0);
    cyc(0,0,0,0,0,0,0,1,1);
    cyc(1,1,1,0,0,0,0,0,1);      // R8 stall beats setup
    cyc(1,1,1,0,0,0,0,0,0);
    // R10: setup inside a data stage
    cyc(1,0,1,0,0,0,0,0,0);
    cyc(0,0,0,0,1,0,0,0,0);
    cyc(1,1,1,0,0,0,0,0,0);
    cyc(0,0,0,0,0,0,0,0,1);      // R8 from a data stage
    cyc(1,0,0,0,0,0,0,0,0);

    // R1: asynchronous reset in the middle of a data stage
    cyc(1,1,1,0,0,0,0,0,0);
    #1 rst_n = 1'b0;
    #0.5;
    mdl[0] = 1; mdl[1] = 1;
    check_one("R1", "preempt", st_a, ei_a, eo_a, sl_a, 1);
    check_one("R1", "hold", st_b, ei_b, eo_b, sl_b, 1);
    @(negedge clk);
    rst_n = 1'b1;
    idle(1);

    // mixed traffic, every cycle compared
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom % 100;
      cyc(r < 12, $urandom % 2 == 0, $urandom % 4 != 0, r >= 12 && r < 30,
          r >= 30 && r < 42, r >= 42 && r < 62, $urandom % 3 == 0,
          r >= 62 && r < 74, r >= 97);
    end
    finish_run();
  end
endmodule